// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (I2C-style) that gives single-byte access to a sixteen-entry register space. Its seven-bit bus address combines a fixed upper nibble of `0111` with three strap inputs as the low bits. Several copies can therefore share one bus if each has its own strap setting.

The block handles three transfers. A write carries a register-address byte and one data byte. A random read sets the register pointer and then fetches a byte after a repeated START. A current-address read fetches the byte at the pointer left by the last access. Each transaction moves exactly one byte, and the pointer never advances by itself.

SCL and SDA enter through synchronizers and are sampled with the system clock. The slave pulls SDA low only through an output-enable signal. The low part of the address space holds read-write registers, and their contents appear on a parallel output. The next group of addresses holds read-only identification constants. Every other address reads as zero.

Top module: `twi_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `0111` followed by strap[2:0] (strap[2] as the most significant of the three), with bit 0 being R/W (0 = write, 1 = read). On any other address it does not acknowledge, and it ignores every following byte until the next START or STOP.
- R2: A write is START, address with R/W=0, register-address byte, data byte, STOP. The slave acknowledges all three bytes. For a register address from 0 to 7, the data lands in cfgOut[8*addr+7 : 8*addr].
- R3: A random read (register-address write, repeated START, address with R/W=1) returns the addressed register. The slave shifts the byte out most significant bit first.
- R4: A current-address read (START, then address with R/W=1) returns the register at the most recently latched register address.
- R5: The register pointer does not advance after a read or a write, so repeated current-address reads return the same register.
- R6: Addresses 8 to 11 are read-only and return 0xA0 plus (address - 8). A write to them is acknowledged and changes no register.
- R7: Addresses 12 to 255 read as 0x00. A write to them is acknowledged and changes no register.
- R8: After the read data byte, the slave releases SDA whether the master answers with ACK or NACK. It drives nothing more until a new START.
- R9: The slave changes SDA only while SCL is low. It releases SDA (sdaOe low) whenever it is not driving an acknowledge or a zero data bit.
- R10: After reset, SDA is released, every read-write register is 0x00 and the register pointer is 0.
- R11: In a write, any byte after the data byte goes unacknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | High pulls the data line low |
| strap | input | 3 | Low three bits of the bus address |
| cfgOut | output | 64 | Read-write registers 0 to 7, register i in bits 8*i+7 to 8*i |

## Verification
The bench builds the block with its default parameters: eight read-write registers, four read-only registers based at 0xA0, and two synchronizer stages. With these values the read-write, read-only and unimplemented ranges all sit inside the sixteen register addresses, and an address far outside them (0x80) is also reached. The strap inputs change between transactions, so both matching and non-matching addresses are exercised. The bus runs slowly against the system clock, so the synchronizer and edge-detect delay fits inside each SCL phase.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } busState_t;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic wrReg;
    logic loadTx;
    logic shiftTx;
  } ctlStrobe_t;

endpackage

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX  = 4'b0111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output ctlStrobe_t ctl,
  output logic       rxBit,
  output logic       sdaOe
);

  localparam logic [3:0] BYTE_BITS = 4'd8;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startSeen, stopSeen, quiet, byteDone, addrMatch;
  logic [6:0] devAddr;
  logic [3:0] bitCnt;
  logic isRead;
  busState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startSeen = sclS & sclP & sdaP & ~sdaS;
  assign stopSeen  = sclS & sclP & ~sdaP & sdaS;
  assign quiet     = ~startSeen & ~stopSeen;
  assign byteDone  = sclFall && (bitCnt == BYTE_BITS);
  assign devAddr   = {DEV_PREFIX, strap};
  assign addrMatch = (rxByte[7:1] == devAddr);
  assign rxBit     = sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_REG, ST_DATA, ST_TX: begin
          if (sclRise && bitCnt < BYTE_BITS) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            unique case (state)
              ST_ADDR: begin
                if (addrMatch) begin
                  state  <= ST_ADDR_ACK;
                  isRead <= rxByte[0];
                end else begin
                  state <= ST_SKIP;
                end
              end
              ST_REG:  state <= ST_REG_ACK;
              ST_DATA: state <= ST_DATA_ACK;
              default: state <= ST_TX_ACK;
            endcase
          end
        end
        ST_ADDR_ACK: if (sclFall) state <= isRead ? ST_TX : ST_REG;
        ST_REG_ACK:  if (sclFall) state <= ST_DATA;
        ST_DATA_ACK: if (sclFall) state <= ST_SKIP;
        ST_TX_ACK:   if (sclRise) state <= ST_IDLE;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.shiftIn = quiet && sclRise && (bitCnt < BYTE_BITS) &&
                  (state == ST_ADDR || state == ST_REG || state == ST_DATA);
    ctl.setPtr  = quiet && byteDone && (state == ST_REG);
    ctl.wrReg   = quiet && byteDone && (state == ST_DATA);
    ctl.loadTx  = quiet && sclFall && isRead && (state == ST_ADDR_ACK);
    ctl.shiftTx = quiet && sclFall && (bitCnt < BYTE_BITS) && (state == ST_TX);
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_REG_ACK) ||
                 (state == ST_DATA_ACK) || ((state == ST_TX) && !txMsb);

  // R9: output enable moves only while the bus clock is low
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

  // R1: foreign address is never acknowledged
  assert_nack_foreign_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteDone && quiet && !addrMatch) |=> !sdaOe);

  // R1: own address is acknowledged
  assert_ack_own_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteDone && quiet && addrMatch) |=> sdaOe);

endmodule

// File: rtl/twi_data.sv
module twi_data
  import twi_pkg::*;
#(
  parameter int         NUM_RW  = 8,
  parameter int         NUM_RO  = 4,
  parameter logic [7:0] RO_BASE = 8'hA0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic                rxBit,
  output logic [7:0]          rxByte,
  output logic                txMsb,
  output logic [NUM_RW*8-1:0] cfgOut
);

  localparam int NUM_ADDR  = 16;
  localparam int IMPL_LAST = NUM_RW + NUM_RO;

  logic [7:0] ptr, txShift, readVal;
  logic [7:0] rwReg [NUM_RW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      ptr     <= '0;
      txShift <= '0;
    end else begin
      if (ctl.shiftIn) rxByte <= {rxByte[6:0], rxBit};
      if (ctl.setPtr)  ptr    <= rxByte;
      if (ctl.loadTx)       txShift <= readVal;
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NUM_RW; g++) begin : gRw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               rwReg[g] <= '0;
      else if (ctl.wrReg && ptr == 8'(g))      rwReg[g] <= rxByte;
    end
    assign cfgOut[8*g +: 8] = rwReg[g];
  end

  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (ptr == 8'(i)) readVal = rwReg[i];
    for (int j = 0; j < NUM_RO; j++)
      if (ptr == 8'(NUM_RW + j)) readVal = RO_BASE + 8'(j);
  end

  assign txMsb = txShift[7];

  initial begin
    assert_fits_space_R7: assert (IMPL_LAST <= NUM_ADDR);
  end

  // R5: a register write never moves the pointer
  assert_no_autoinc_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrReg |=> $stable(ptr));

  // R2: at most one datapath action per cycle
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl));

endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
  import twi_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX  = 4'b0111,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_RW      = 8,
  parameter int         NUM_RO      = 4,
  parameter logic [7:0] RO_BASE     = 8'hA0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  input  logic [2:0]          strap,
  output logic [NUM_RW*8-1:0] cfgOut
);

  ctlStrobe_t ctl;
  logic rxBit, txMsb;
  logic [7:0] rxByte;

  twi_ctrl #(.DEV_PREFIX(DEV_PREFIX), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .rxByte(rxByte), .txMsb(txMsb), .ctl(ctl), .rxBit(rxBit), .sdaOe(sdaOe)
  );

  twi_data #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .RO_BASE(RO_BASE)) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit),
    .rxByte(rxByte), .txMsb(txMsb), .cfgOut(cfgOut)
  );

endmodule

// File: tb/twi_reg_slave_tb_top.sv
`timescale 1ns/1ps
module twi_reg_slave_tb_top;

  localparam int Q = 100;
  localparam int H = 200;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, mSda = 1'b1;
  logic [2:0] strap = 3'b010;
  logic sdaOe;
  logic [63:0] cfgOut;
  wire sdaBus = mSda & ~sdaOe;

  int checks = 0, fails = 0, oeViol = 0;
  bit monOn = 0, done = 0;
  logic [7:0] expRw [8];

  always #5 clk = ~clk;

  twi_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strap(strap), .cfgOut(cfgOut)
  );

  always @(sdaOe) if (monOn && scl) oeViol++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expCfg();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = expRw[i];
    return v;
  endfunction

  task automatic busStart();
    mSda = 1; scl = 1; #Q; mSda = 0; #Q; scl = 0; #Q;
  endtask
  task automatic busRestart();
    mSda = 1; #Q; scl = 1; #Q; mSda = 0; #Q; scl = 0; #Q;
  endtask
  task automatic busStop();
    mSda = 0; #Q; scl = 1; #Q; mSda = 1; #Q;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; #Q; scl = 1; #H; scl = 0; #Q;
    end
    mSda = 1; #Q; scl = 1; #(H/2); ack = (sdaBus == 1'b0); #(H/2); scl = 0; #Q;
  endtask

  task automatic readByte(output logic [7:0] d, input bit masterAck);
    mSda = 1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1; #(H/2); d[i] = sdaBus; #(H/2); scl = 0;
    end
    #Q; mSda = masterAck ? 1'b0 : 1'b1; #Q; scl = 1; #H; scl = 0; #Q; mSda = 1; #Q;
  endtask

  function automatic logic [7:0] devByte(input bit rd);
    return {4'b0111, strap, rd};
  endfunction

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d, output bit [2:0] acks);
    bit k;
    busStart();
    sendByte(devByte(0), k); acks[2] = k;
    sendByte(a, k);          acks[1] = k;
    sendByte(d, k);          acks[0] = k;
    busStop();
  endtask

  task automatic randRead(input logic [7:0] a, input bit mAck, output logic [7:0] d, output bit [2:0] acks);
    bit k;
    busStart();
    sendByte(devByte(0), k); acks[2] = k;
    sendByte(a, k);          acks[1] = k;
    busRestart();
    sendByte(devByte(1), k); acks[0] = k;
    readByte(d, mAck);
    busStop();
  endtask

  task automatic curRead(output logic [7:0] d, output bit ack);
    busStart();
    sendByte(devByte(1), ack);
    readByte(d, 1'b0);
    busStop();
  endtask

  task automatic testReset();
    logic [7:0] d; bit a;
    check("R10 sdaOe after reset", sdaOe, 0);
    check("R10 registers after reset", cfgOut, 0);
    curRead(d, a);
    check("R10 pointer 0 read ack", a, 1);
    check("R10 pointer 0 read data", d, 0);
  endtask

  task automatic testWrite();
    bit [2:0] acks;
    writeReg(8'h03, 8'h5A, acks); expRw[3] = 8'h5A;
    check("R2 three acks", acks, 3'b111);
    check("R2 register 3 written", cfgOut, expCfg());
    writeReg(8'h00, 8'hC3, acks); expRw[0] = 8'hC3;
    check("R2 register 0 written", cfgOut, expCfg());
  endtask

  task automatic testRandRead();
    logic [7:0] d; bit [2:0] acks;
    randRead(8'h03, 0, d, acks);
    check("R3 random read acks", acks, 3'b111);
    check("R3 random read reg 3 msb first", d, 8'h5A);
    randRead(8'h00, 0, d, acks);
    check("R3 random read reg 0", d, 8'hC3);
  endtask

  task automatic testCurRead();
    logic [7:0] d; bit a;
    curRead(d, a);
    check("R4 current read ack", a, 1);
    check("R4 current read uses latched pointer", d, 8'hC3);
    curRead(d, a);
    check("R5 repeated current read no increment", d, 8'hC3);
  endtask

  task automatic testReadOnly();
    logic [7:0] d; bit [2:0] acks;
    writeReg(8'h09, 8'hFF, acks);
    check("R6 write to read-only acked", acks, 3'b111);
    check("R6 write to read-only no change", cfgOut, expCfg());
    randRead(8'h09, 0, d, acks);
    check("R6 read-only reg 9", d, 8'hA1);
    randRead(8'h08, 0, d, acks);
    check("R6 read-only reg 8", d, 8'hA0);
    randRead(8'h0B, 0, d, acks);
    check("R6 read-only reg 11", d, 8'hA3);
  endtask

  task automatic testUnimpl();
    logic [7:0] d; bit [2:0] acks;
    randRead(8'h0D, 0, d, acks);
    check("R7 unimplemented 0x0D reads zero", d, 8'h00);
    randRead(8'h80, 0, d, acks);
    check("R7 unimplemented 0x80 reads zero", d, 8'h00);
    writeReg(8'h0E, 8'h3C, acks);
    check("R7 write to unimplemented acked", acks, 3'b111);
    check("R7 write to unimplemented no change", cfgOut, expCfg());
  endtask

  task automatic testForeign();
    bit k; bit [2:0] acks;
    busStart();
    sendByte({4'b0111, 3'b011, 1'b0}, k);
    check("R1 wrong strap bits not acked", k, 0);
    sendByte(8'h01, k);
    check("R1 byte after mismatch ignored", k, 0);
    sendByte(8'hEE, k);
    check("R1 data after mismatch ignored", k, 0);
    busStop();
    check("R1 no register change on mismatch", cfgOut, expCfg());
    busStart();
    sendByte({4'b0110, strap, 1'b0}, k);
    check("R1 wrong prefix not acked", k, 0);
    busStop();
    strap = 3'b101;
    writeReg(8'h01, 8'h96, acks); expRw[1] = 8'h96;
    check("R1 new strap value acked", acks, 3'b111);
    check("R1 write with new strap", cfgOut, expCfg());
  endtask

  task automatic testReadRelease();
    logic [7:0] d; bit [2:0] acks; bit k;
    busStart();
    sendByte(devByte(0), k);
    sendByte(8'h03, k);
    busRestart();
    sendByte(devByte(1), k);
    readByte(d, 1'b1);
    check("R8 data before master ack", d, 8'h5A);
    check("R8 released after master ack", sdaOe, 0);
    readByte(d, 1'b0);
    check("R8 no second byte driven", d, 8'hFF);
    busStop();
    randRead(8'h00, 0, d, acks);
    check("R8 released after master nack", sdaOe, 0);
    check("R8 read after nack", d, 8'hC3);
  endtask

  task automatic testExtraByte();
    bit k;
    busStart();
    sendByte(devByte(0), k);
    sendByte(8'h05, k);
    sendByte(8'h77, k); expRw[5] = 8'h77;
    check("R11 data byte acked", k, 1);
    sendByte(8'h99, k);
    check("R11 extra byte not acked", k, 0);
    busStop();
    check("R11 R5 only register 5 written", cfgOut, expCfg());
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 8; i++) expRw[i] = 8'h00;
    #2;
    #(5*Q);
    rstN = 1;
    #(2*Q);
    monOn = 1;
    testReset();
    testWrite();
    testRandRead();
    testCurRead();
    testReadOnly();
    testUnimpl();
    testForeign();
    testReadRelease();
    testExtraByte();
    check("R9 sdaOe changed only with SCL low", oeViol, 0);
    finishRun();
  end

endmodule